// File: doc/BRIEF.md
# Automatic Transmit/Receive Pin Switcher

This block controls one bank of general-purpose I/O pins that run to a daughter card. Software sets the output level and the direction of each pin through masked register writes, and a two-flop synchronizer returns the pin levels for reading. Automatic switching can also be turned on. The pins picked by a selection mask then leave the normal output register and follow one of two preset words: the transmit word or the receive word.

The choice between the presets comes from an internal transmit indication. That indication follows the transmit FIFO's non-empty flag, but only after a programmable number of clock ticks, and the count is set separately for the rising and the falling edge. If the FIFO flag returns to its old state before the count runs out, the pending change is dropped. Antenna switches and amplifier enables on the card can then change state with a set margin around each burst.

Top module: `atr_pin_switch`

## Requirements
- R1: After reset every register reads as zero, so pin_oe is all zero, pin_out is all zero and automatic switching is off.
- R2: A write to address 1 updates the output-enable register only in the bits where wr_mask is 1. pin_oe shows the register directly, and a 1 makes that pin an output.
- R3: A write to address 0 updates the normal output register only in the bits where wr_mask is 1. While switching is off (control bit 0 clear), pin_out equals that register on every bit.
- R4: While switching is on, a pin whose bit in the selection mask is 0 keeps the value of the normal output register.
- R5: While switching is on, a pin whose selection bit is 1 drives the transmit word bit when the transmit indication is high, and the receive word bit when it is low.
- R6: With rise count D, the transmit indication goes high once fifo_nonempty has been sampled high at D+1 consecutive clock edges. pin_out changes after that edge.
- R7: With fall count D, the transmit indication goes low once fifo_nonempty has been sampled low at D+1 consecutive clock edges.
- R8: If fifo_nonempty returns to the indication's current value before the count expires, the indication does not change, and the next change starts counting from zero again.
- R9: pin_in_sync shows pin_in two clock edges after it is applied, and not after only one.
- R10: The registers at addresses 2 to 7 take wr_data directly and ignore wr_mask. The map is: 2 control (bit 0 enables switching, other bits ignored), 3 selection mask, 4 transmit word, 5 receive word, 6 rise count, 7 fall count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Write data |
| wr_mask | input | 16 | Bit mask for the I/O and output-enable writes |
| fifo_nonempty | input | 1 | Transmit FIFO holds data |
| pin_out | output | 16 | Value driven toward the pins |
| pin_oe | output | 16 | Per-pin output enable |
| pin_in | input | 16 | Raw pin levels |
| pin_in_sync | output | 16 | Synchronized pin levels |

## Verification
On every cycle the assertions check the masked update of the direction register, that it stays put without a write, and the per-bit pin source: the normal register when switching is off or a pin is unselected, otherwise the preset picked by the indication. They also check that the indication changes only toward the FIFO flag and never while the two agree. The exact tick counts of the rise and fall delays, the cancelled transition and the synchronizer latency depend on counted histories, so only the bench's timed scenarios can show them.

// File: rtl/atr_pkg.sv
package atr_pkg;
   typedef enum logic [2:0] {
      REG_IO   = 3'd0,
      REG_OE   = 3'd1,
      REG_CTRL = 3'd2,
      REG_SEL  = 3'd3,
      REG_TXW  = 3'd4,
      REG_RXW  = 3'd5,
      REG_RISE = 3'd6,
      REG_FALL = 3'd7
   } atr_reg_e;

   localparam int ADDR_W = 3;
endpackage

// File: rtl/atr_regfile.sv
module atr_regfile
   import atr_pkg::*;
#(
   parameter int NPINS  = 16,
   parameter int DATA_W = 32,
   parameter int DLY_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [NPINS-1:0]  wr_mask,
   output logic [NPINS-1:0]  io_q,
   output logic [NPINS-1:0]  oe_q,
   output logic              en_q,
   output logic [NPINS-1:0]  sel_q,
   output logic [NPINS-1:0]  txw_q,
   output logic [NPINS-1:0]  rxw_q,
   output logic [DLY_W-1:0]  rise_q,
   output logic [DLY_W-1:0]  fall_q
);
   atr_reg_e              addr;
   logic [NPINS-1:0]      dpins;
   logic [DLY_W-1:0]      ddly;

   assign addr  = atr_reg_e'(wr_addr);
   assign dpins = wr_data[NPINS-1:0];
   assign ddly  = wr_data[DLY_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         io_q   <= '0;
         oe_q   <= '0;
         en_q   <= 1'b0;
         sel_q  <= '0;
         txw_q  <= '0;
         rxw_q  <= '0;
         rise_q <= '0;
         fall_q <= '0;
      end else if (wr_en) begin
         case (addr)
            REG_IO:   io_q   <= (io_q & ~wr_mask) | (dpins & wr_mask);
            REG_OE:   oe_q   <= (oe_q & ~wr_mask) | (dpins & wr_mask);
            REG_CTRL: en_q   <= wr_data[0];
            REG_SEL:  sel_q  <= dpins;
            REG_TXW:  txw_q  <= dpins;
            REG_RXW:  rxw_q  <= dpins;
            REG_RISE: rise_q <= ddly;
            REG_FALL: fall_q <= ddly;
            default:  ;
         endcase
      end
   end
endmodule

// File: rtl/atr_tx_delay.sv
module atr_tx_delay #(
   parameter int DLY_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_ne,
   input  logic [DLY_W-1:0] rise_dly,
   input  logic [DLY_W-1:0] fall_dly,
   output logic             tx_ind
);
   logic [DLY_W-1:0] cnt;
   logic [DLY_W-1:0] target;
   logic             differ;

   assign differ = fifo_ne ^ tx_ind;
   assign target = tx_ind ? fall_dly : rise_dly;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_ind <= 1'b0;
         cnt    <= '0;
      end else if (!differ) begin
         cnt    <= '0;
      end else if (cnt >= target) begin
         tx_ind <= fifo_ne;
         cnt    <= '0;
      end else begin
         cnt    <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/atr_pin_mux.sv
module atr_pin_mux #(
   parameter int NPINS = 16
) (
   input  logic             en,
   input  logic             tx_ind,
   input  logic [NPINS-1:0] io_val,
   input  logic [NPINS-1:0] sel,
   input  logic [NPINS-1:0] txw,
   input  logic [NPINS-1:0] rxw,
   output logic [NPINS-1:0] pins
);
   for (genvar b = 0; b < NPINS; b++) begin : g_bit
      logic preset;
      assign preset  = tx_ind ? txw[b] : rxw[b];
      assign pins[b] = (en && sel[b]) ? preset : io_val[b];
   end
endmodule

// File: rtl/atr_in_sync.sv
module atr_in_sync #(
   parameter int NPINS  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] d,
   output logic [NPINS-1:0] q
);
   logic [NPINS-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/atr_pin_switch.sv
module atr_pin_switch
   import atr_pkg::*;
#(
   parameter int NPINS       = 16,
   parameter int DATA_W      = 32,
   parameter int DLY_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [NPINS-1:0]  wr_mask,
   input  logic              fifo_nonempty,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_in_sync
);
   if (NPINS > DATA_W) begin : g_bad_pins
      $error("NPINS must not exceed DATA_W");
   end
   if (DLY_W > DATA_W) begin : g_bad_dly
      $error("DLY_W must not exceed DATA_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NPINS-1:0] io_q, oe_q, sel_q, txw_q, rxw_q;
   logic             en_q, tx_ind;
   logic [DLY_W-1:0] rise_q, fall_q;

   atr_regfile #(.NPINS(NPINS), .DATA_W(DATA_W), .DLY_W(DLY_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_mask(wr_mask),
      .io_q(io_q), .oe_q(oe_q), .en_q(en_q), .sel_q(sel_q),
      .txw_q(txw_q), .rxw_q(rxw_q), .rise_q(rise_q), .fall_q(fall_q)
   );

   atr_tx_delay #(.DLY_W(DLY_W)) u_dly (
      .clk(clk), .rst_n(rst_n), .fifo_ne(fifo_nonempty),
      .rise_dly(rise_q), .fall_dly(fall_q), .tx_ind(tx_ind)
   );

   atr_pin_mux #(.NPINS(NPINS)) u_mux (
      .en(en_q), .tx_ind(tx_ind), .io_val(io_q), .sel(sel_q),
      .txw(txw_q), .rxw(rxw_q), .pins(pin_out)
   );

   atr_in_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_in_sync)
   );

   assign pin_oe = oe_q;
endmodule

// File: rtl/atr_pin_switch_chk.sv
module atr_pin_switch_chk
   import atr_pkg::*;
#(
   parameter int NPINS  = 16,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [NPINS-1:0]  wr_mask,
   input logic              fifo_nonempty,
   input logic [NPINS-1:0]  pin_out,
   input logic [NPINS-1:0]  pin_oe,
   input logic [NPINS-1:0]  io_q,
   input logic              en_q,
   input logic [NPINS-1:0]  sel_q,
   input logic [NPINS-1:0]  txw_q,
   input logic [NPINS-1:0]  rxw_q,
   input logic              tx_ind
);
   logic oe_wr;
   assign oe_wr = wr_en && (wr_addr == 3'd1);

   a_r2_oe_masked: assert property (@(posedge clk) disable iff (!rst_n)
      oe_wr |=> pin_oe == (($past(pin_oe) & ~$past(wr_mask)) |
                           ($past(wr_data[NPINS-1:0]) & $past(wr_mask))));

   a_r2_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_wr |=> $stable(pin_oe));

   a_r3_disabled_io: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> pin_out == io_q);

   a_r4_unselected_io: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |-> ((pin_out ^ io_q) & ~sel_q) == '0);

   a_r5_preset_source: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |-> ((pin_out ^ (tx_ind ? txw_q : rxw_q)) & sel_q) == '0);

   a_r8_no_change_when_equal: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_nonempty == tx_ind) |=> $stable(tx_ind));

   a_r6_rise_follows_fifo: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_ind) |-> $past(fifo_nonempty));

   a_r7_fall_follows_fifo: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_ind) |-> !$past(fifo_nonempty));
endmodule

bind atr_pin_switch atr_pin_switch_chk #(.NPINS(NPINS), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .wr_mask(wr_mask), .fifo_nonempty(fifo_nonempty),
   .pin_out(pin_out), .pin_oe(pin_oe), .io_q(io_q), .en_q(en_q),
   .sel_q(sel_q), .txw_q(txw_q), .rxw_q(rxw_q), .tx_ind(tx_ind)
);

// File: tb/test_atr_pin_switch.sv
module test_atr_pin_switch;
   localparam int N = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic [N-1:0]  wr_mask = '0;
   logic          fifo_nonempty = 1'b0;
   logic [N-1:0]  pin_out, pin_oe, pin_in_sync;
   logic [N-1:0]  pin_in = '0;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   atr_pin_switch i_atr_pin_switch (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_mask(wr_mask), .fifo_nonempty(fifo_nonempty),
      .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in),
      .pin_in_sync(pin_in_sync)
   );

   // Table: io, select, tx word, rx word, enable, fifo (delays zero)
   localparam int NV = 5;
   localparam logic [N-1:0] V_IO  [NV] = '{16'h1234, 16'hFFFF, 16'h0F0F, 16'hA5A5, 16'h0000};
   localparam logic [N-1:0] V_SEL [NV] = '{16'hFFFF, 16'h00FF, 16'hF0F0, 16'h0000, 16'h8001};
   localparam logic [N-1:0] V_TX  [NV] = '{16'hAAAA, 16'h1200, 16'hFFFF, 16'hFFFF, 16'hFFFF};
   localparam logic [N-1:0] V_RX  [NV] = '{16'h5555, 16'h0034, 16'h0000, 16'h0000, 16'h7FFE};
   localparam logic         V_EN  [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
   localparam logic         V_FF  [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1};

   function automatic logic [N-1:0] model(input logic [N-1:0] io, sel, txw, rxw,
                                          input logic en, txi);
      logic [N-1:0] p;
      p = txi ? txw : rxw;
      return en ? ((p & sel) | (io & ~sel)) : io;
   endfunction

   task automatic check(input string req, input logic [N-1:0] act, exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [N-1:0] m);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; wr_mask = m;
      @(negedge clk);
      wr_en = 1'b0; wr_mask = '0;
   endtask

   task automatic edges(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
   end

   initial begin
      edges(3);
      rst_n = 1'b1;
      edges(1);
      // R1
      check("R1 oe", pin_oe, 16'h0000);
      check("R1 out", pin_out, 16'h0000);

      // R2 masked output-enable writes
      wr(3'd1, 32'h0000FFFF, 16'h00F0);
      check("R2 oe set", pin_oe, 16'h00F0);
      wr(3'd1, 32'h00000000, 16'h0030);
      check("R2 oe clear", pin_oe, 16'h00C0);

      // R3 masked io writes, switching off
      wr(3'd0, 32'h0000FFFF, 16'h0F00);
      check("R3 io", pin_out, 16'h0F00);
      wr(3'd0, 32'h00001234, 16'hF00F);
      check("R3 io merge", pin_out, 16'h1F04);

      // Table walk, R4 R5 R10, delays zero
      for (int i = 0; i < NV; i++) begin
         wr(3'd0, {16'h0, V_IO[i]}, 16'hFFFF);
         wr(3'd3, {16'hDEAD, V_SEL[i]}, 16'h0000);
         wr(3'd4, {16'h0, V_TX[i]}, 16'h0000);
         wr(3'd5, {16'h0, V_RX[i]}, 16'h0000);
         wr(3'd2, {31'h7FFFFFFE, V_EN[i]}, 16'h0000);
         fifo_nonempty = V_FF[i];
         edges(2);
         check("R4/R5/R10 table", pin_out,
               model(V_IO[i], V_SEL[i], V_TX[i], V_RX[i], V_EN[i], V_FF[i]));
      end

      // Delay setup: all selected, enable on
      wr(3'd0, 32'h0, 16'hFFFF);
      wr(3'd3, 32'hFFFF, 16'h0);
      wr(3'd4, 32'hAAAA, 16'h0);
      wr(3'd5, 32'h5555, 16'h0);
      wr(3'd2, 32'h1, 16'h0);
      fifo_nonempty = 1'b0;
      edges(2);
      check("R5 rx idle", pin_out, 16'h5555);

      // R6 rise count 3
      wr(3'd6, 32'd3, 16'h0);
      wr(3'd7, 32'd2, 16'h0);
      fifo_nonempty = 1'b1;
      edges(3);
      check("R6 before rise", pin_out, 16'h5555);
      edges(1);
      check("R6 after rise", pin_out, 16'hAAAA);

      // R7 fall count 2
      fifo_nonempty = 1'b0;
      edges(2);
      check("R7 before fall", pin_out, 16'hAAAA);
      edges(1);
      check("R7 after fall", pin_out, 16'h5555);

      // R8 cancelled rise, then full recount
      fifo_nonempty = 1'b1;
      edges(2);
      fifo_nonempty = 1'b0;
      edges(1);
      check("R8 cancelled", pin_out, 16'h5555);
      fifo_nonempty = 1'b1;
      edges(3);
      check("R8 recount", pin_out, 16'h5555);
      edges(1);
      check("R8 switched", pin_out, 16'hAAAA);

      // R6 zero rise count
      fifo_nonempty = 1'b0;
      edges(4);
      wr(3'd6, 32'd0, 16'h0);
      fifo_nonempty = 1'b1;
      edges(1);
      check("R6 zero delay", pin_out, 16'hAAAA);

      // R9 synchronizer
      pin_in = 16'hC3A5;
      edges(1);
      check("R9 one edge", pin_in_sync, 16'h0000);
      edges(1);
      check("R9 two edges", pin_in_sync, 16'hC3A5);

      // R1 again through reset
      rst_n = 1'b0;
      edges(2);
      rst_n = 1'b1;
      fifo_nonempty = 1'b0;
      edges(1);
      check("R1 re-reset oe", pin_oe, 16'h0000);
      check("R1 re-reset out", pin_out, 16'h0000);

      summary();
   end
endmodule